// File: doc/BRIEF.md
# Scaled Shift-and-Add Execution Unit

This unit computes a scaled-index sum in one operation. It replaces a separate shift followed by an add in address arithmetic inside hot loops. It decodes a fixed 32-bit instruction word and reads the two source register indices straight from it, so a register file outside the unit can return the operand values in the same cycle. Operand B is shifted left by one to four places and added to operand A. The sum is 64 bits wide and wraps. A word variant first keeps only the low 32 bits of B. The result goes to the register named by the destination field.

The instruction sits in a single output register stage with a valid/ready handshake. When the record bit is set, the unit also reports a three-bit sign condition of the result. Words whose opcodes match neither variant come out marked illegal and carry no result.

Top module: `scaled_add_unit`

## Requirements
- R1: With primary opcode PO_VAL and extended opcode XO_FULL, the result is (B << (sm+1)) + A, where A is `in_a_val` and B is `in_b_val`.
- R2: The shift amount is the 2-bit sm field plus one, so every encoding 0..3 gives a shift of 1, 2, 3 or 4 places.
- R3: With extended opcode XO_WORD, the upper 32 bits of B are cleared before the shift, and the sum with the full 64-bit A is formed as in R1.
- R4: Field layout with bit 31 as the word's MSB: primary opcode [31:26], destination [25:21], source A index [20:16], source B index [15:11], sm [10:9], extended opcode [8:1], record bit [0]. `src_a_idx` and `src_b_idx` follow the input word combinationally, and `out_dest` equals the destination field.
- R5: A word whose primary opcode is not PO_VAL, or whose extended opcode is neither XO_FULL nor XO_WORD, leaves the stage with `out_illegal`=1, `out_wr_en`=0, `out_cond_we`=0, a zero result and zero destination. Legal words give `out_wr_en`=1 and `out_illegal`=0.
- R6: When the record bit is 1, `out_cond_we`=1 and `out_cond` = {negative, positive, zero} of the result read as a signed number. When the record bit is 0, `out_cond_we`=0 and `out_cond`=0.
- R7: `in_ready` is high when the stage is empty or `out_ready` is high. A word accepted at a clock edge appears with `out_valid`=1 after that edge. An empty-input cycle with `out_ready` high empties the stage.
- R8: While `out_valid`=1 and `out_ready`=0, all output fields stay unchanged.
- R9: After a clock edge with `rst` high, `out_valid` and all result and condition outputs are zero.
- R10: The addition wraps modulo 2^64, and the carry out of bit 63 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| in_insn | input | 32 | Instruction word |
| src_a_idx | output | 5 | Source A register index decoded from the word |
| src_b_idx | output | 5 | Source B register index decoded from the word |
| in_a_val | input | 64 | Value of source A |
| in_b_val | input | 64 | Value of source B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Sum |
| out_dest | output | 5 | Destination register index |
| out_wr_en | output | 1 | Result is to be written |
| out_illegal | output | 1 | Word was not a recognised variant |
| out_cond_we | output | 1 | Condition field is to be written |
| out_cond | output | 3 | {negative, positive, zero} |

## Verification
Every legal encoding of the shift field is applied to the same small operands, so a wrong shift distance gives a different sum for each encoding. B values whose upper half is non-zero, run through both variants, show whether that half is cleared only in the word variant. Sums that carry past bit 63, that come out exactly zero or that come out negative test the wrap and each condition bit. Mismatched primary or extended opcodes, random back-pressure and a long random mixed stream, checked against a queue-free reference model each cycle, cover illegal handling, stalls and the handshake.

// File: rtl/ssa_pkg.sv
package ssa_pkg;

    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int IDXW  = 5;
    localparam int SMW   = 2;
    localparam int NSH   = 1 << SMW;
    localparam int POW   = 6;
    localparam int XOW   = 8;
    localparam int CRW   = 3;

    localparam logic [POW-1:0] DEF_PO      = 6'd22;
    localparam logic [XOW-1:0] DEF_XO_FULL = 8'd110;
    localparam logic [XOW-1:0] DEF_XO_WORD = 8'd111;

    typedef enum logic [1:0] {
        VAR_NONE = 2'd0,
        VAR_FULL = 2'd1,
        VAR_WORD = 2'd2
    } variant_e;

    // Field order in the packed struct follows the word from its MSB down.
    typedef struct packed {
        logic [POW-1:0]  po;
        logic [IDXW-1:0] rt;
        logic [IDXW-1:0] ra;
        logic [IDXW-1:0] rb;
        logic [SMW-1:0]  sm;
        logic [XOW-1:0]  xo;
        logic            rc;
    } insn_fields_t;

    typedef struct packed {
        variant_e        kind;
        logic [IDXW-1:0] rt;
        logic [SMW-1:0]  sm;
        logic            rc;
    } decoded_t;

    typedef struct packed {
        logic [XLEN-1:0] sum;
        logic [IDXW-1:0] dest;
        logic            illegal;
        logic            we;
        logic            cr_we;
        logic [CRW-1:0]  cr;
    } result_t;

    function automatic logic [CRW-1:0] sign_cond(input logic [XLEN-1:0] v);
        logic neg;
        logic zer;
        neg = v[XLEN-1];
        zer = (v == '0);
        return {neg, ~neg & ~zer, zer};
    endfunction

endpackage

// File: rtl/ssa_decode.sv
module ssa_decode
    import ssa_pkg::*;
#(
    parameter logic [POW-1:0] PO_VAL  = DEF_PO,
    parameter logic [XOW-1:0] XO_FULL = DEF_XO_FULL,
    parameter logic [XOW-1:0] XO_WORD = DEF_XO_WORD
) (
    input  logic [31:0]     insn,
    output decoded_t        dec,
    output logic [IDXW-1:0] ra_idx,
    output logic [IDXW-1:0] rb_idx
);
    insn_fields_t f;
    assign f = insn_fields_t'(insn);

    variant_e kind;
    always_comb begin
        kind = VAR_NONE;
        if (f.po == PO_VAL) begin
            if (f.xo == XO_FULL)      kind = VAR_FULL;
            else if (f.xo == XO_WORD) kind = VAR_WORD;
        end
    end

    assign dec.kind = kind;
    assign dec.rt   = f.rt;
    assign dec.sm   = f.sm;
    assign dec.rc   = f.rc;
    assign ra_idx   = f.ra;
    assign rb_idx   = f.rb;
endmodule

// File: rtl/ssa_datapath.sv
module ssa_datapath
    import ssa_pkg::*;
(
    input  decoded_t        dec,
    input  logic [XLEN-1:0] a_val,
    input  logic [XLEN-1:0] b_val,
    output result_t         res
);
    logic [XLEN-1:0] b_sel;
    logic [XLEN-1:0] cand [NSH];
    logic [XLEN-1:0] sum;
    logic            legal;

    assign legal = (dec.kind != VAR_NONE);
    assign b_sel = (dec.kind == VAR_WORD) ? {{HALF{1'b0}}, b_val[HALF-1:0]} : b_val;

    for (genvar g = 0; g < NSH; g++) begin : g_shift
        assign cand[g] = b_sel << (g + 1);
    end

    assign sum = a_val + cand[dec.sm];

    always_comb begin
        res = '0;
        if (legal) begin
            res.sum   = sum;
            res.dest  = dec.rt;
            res.we    = 1'b1;
            res.cr_we = dec.rc;
            res.cr    = dec.rc ? sign_cond(sum) : '0;
        end else begin
            res.illegal = 1'b1;
        end
    end
endmodule

// File: rtl/ssa_stage.sv
module ssa_stage
    import ssa_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    up_valid,
    output logic    up_ready,
    input  result_t up_data,
    output logic    dn_valid,
    input  logic    dn_ready,
    output result_t dn_data
);
    logic    vld_q;
    result_t dat_q;

    assign up_ready = ~vld_q | dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            dat_q <= '0;
        end else if (up_ready) begin
            vld_q <= up_valid;
            if (up_valid) dat_q <= up_data;
        end
    end

    assign dn_valid = vld_q;
    assign dn_data  = dat_q;
endmodule

// File: rtl/scaled_add_unit.sv
module scaled_add_unit
    import ssa_pkg::*;
#(
    parameter logic [POW-1:0] PO_VAL  = DEF_PO,
    parameter logic [XOW-1:0] XO_FULL = DEF_XO_FULL,
    parameter logic [XOW-1:0] XO_WORD = DEF_XO_WORD
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [31:0]     in_insn,
    output logic [IDXW-1:0] src_a_idx,
    output logic [IDXW-1:0] src_b_idx,
    input  logic [XLEN-1:0] in_a_val,
    input  logic [XLEN-1:0] in_b_val,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [XLEN-1:0] out_result,
    output logic [IDXW-1:0] out_dest,
    output logic            out_wr_en,
    output logic            out_illegal,
    output logic            out_cond_we,
    output logic [CRW-1:0]  out_cond
);
    decoded_t dec;
    result_t  res_c;
    result_t  res_q;

    ssa_decode #(
        .PO_VAL (PO_VAL),
        .XO_FULL(XO_FULL),
        .XO_WORD(XO_WORD)
    ) u_dec (
        .insn  (in_insn),
        .dec   (dec),
        .ra_idx(src_a_idx),
        .rb_idx(src_b_idx)
    );

    ssa_datapath u_dp (
        .dec  (dec),
        .a_val(in_a_val),
        .b_val(in_b_val),
        .res  (res_c)
    );

    ssa_stage u_stage (
        .clk     (clk),
        .rst     (rst),
        .up_valid(in_valid),
        .up_ready(in_ready),
        .up_data (res_c),
        .dn_valid(out_valid),
        .dn_ready(out_ready),
        .dn_data (res_q)
    );

    assign out_result  = res_q.sum;
    assign out_dest    = res_q.dest;
    assign out_wr_en   = res_q.we;
    assign out_illegal = res_q.illegal;
    assign out_cond_we = res_q.cr_we;
    assign out_cond    = res_q.cr;
endmodule

// File: rtl/scaled_add_unit_chk.sv
module scaled_add_unit_chk
    import ssa_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic            in_ready,
    input logic            out_valid,
    input logic            out_ready,
    input logic [XLEN-1:0] out_result,
    input logic [IDXW-1:0] out_dest,
    input logic            out_wr_en,
    input logic            out_illegal,
    input logic            out_cond_we,
    input logic [CRW-1:0]  out_cond
);
    // R9: reset clears the stage
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0 && out_cond == '0 && !out_cond_we));

    // R7: an accepted word is presented after the edge
    assert_accept_shows_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R8: stalled output holds
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_dest)
                                       && $stable(out_cond) && $stable(out_cond_we)
                                       && $stable(out_illegal)));

    // R5: an illegal word carries no result
    assert_illegal_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (!out_wr_en && !out_cond_we && out_result == '0));

    // R6: condition field is one-hot when written, zero otherwise
    assert_cond_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cond_we) |-> ($countones(out_cond) == 1));
    assert_cond_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_cond_we) |-> (out_cond == '0));
    assert_cond_sign_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_cond_we) |-> (out_cond[2] == out_result[XLEN-1]
                                        && out_cond[0] == (out_result == '0)));
endmodule

bind scaled_add_unit scaled_add_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result),
    .out_dest   (out_dest),
    .out_wr_en  (out_wr_en),
    .out_illegal(out_illegal),
    .out_cond_we(out_cond_we),
    .out_cond   (out_cond)
);

// File: tb/scaled_add_unit_bench.sv
module scaled_add_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic [4:0]  src_a_idx;
    logic [4:0]  src_b_idx;
    logic [63:0] in_a_val = '0;
    logic [63:0] in_b_val = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_result;
    logic [4:0]  out_dest;
    logic        out_wr_en;
    logic        out_illegal;
    logic        out_cond_we;
    logic [2:0]  out_cond;

    int tests = 0;
    int fails = 0;

    localparam logic [5:0] PO = 6'd22;
    localparam logic [7:0] XF = 8'd110;
    localparam logic [7:0] XW = 8'd111;

    always #2 clk = ~clk;

    scaled_add_unit u_scaled_add_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
        .in_a_val(in_a_val), .in_b_val(in_b_val), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result), .out_dest(out_dest),
        .out_wr_en(out_wr_en), .out_illegal(out_illegal),
        .out_cond_we(out_cond_we), .out_cond(out_cond)
    );

    // reference model state (contents of the output stage)
    logic        m_valid = 1'b0;
    logic [63:0] m_res = '0;
    logic [4:0]  m_dest = '0;
    logic        m_ill = 1'b0;
    logic        m_we = 1'b0;
    logic        m_cwe = 1'b0;
    logic [2:0]  m_cr = '0;
    logic        m_word = 1'b0;
    logic        m_stalled = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt,
                                       input logic [4:0] ra, input logic [4:0] rb,
                                       input logic [1:0] sm, input logic [7:0] xo,
                                       input logic rc);
        return {po, rt, ra, rb, sm, xo, rc};
    endfunction

    task automatic model_load(input logic [31:0] w, input logic [63:0] a, input logic [63:0] b);
        logic        full;
        logic        word;
        logic [63:0] bb;
        int          sh;
        full = (w[31:26] == PO) && (w[8:1] == XF);
        word = (w[31:26] == PO) && (w[8:1] == XW);
        sh   = int'(w[10:9]) + 1;
        m_valid = 1'b1;
        m_word  = word;
        if (full || word) begin
            bb     = word ? (b & 64'h0000_0000_FFFF_FFFF) : b;
            m_res  = a + (bb << sh);
            m_dest = w[25:21];
            m_ill  = 1'b0;
            m_we   = 1'b1;
            m_cwe  = w[0];
            if (!w[0])               m_cr = 3'b000;
            else if ($signed(m_res) < 0) m_cr = 3'b100;
            else if (m_res == 64'd0) m_cr = 3'b001;
            else                     m_cr = 3'b010;
        end else begin
            m_res = '0; m_dest = '0; m_ill = 1'b1; m_we = 1'b0; m_cwe = 1'b0; m_cr = '0;
        end
    endtask

    // one clock cycle: drive at a falling edge, compare at the next one
    task automatic cyc(input logic v, input logic [31:0] w, input logic [63:0] a,
                       input logic [63:0] b, input logic rdy);
        logic mready;
        in_valid = v; in_insn = w; in_a_val = a; in_b_val = b; out_ready = rdy;
        #1;
        mready = !m_valid || rdy;
        check("R7", "in_ready", 64'(in_ready), 64'(mready));
        check("R4", "src_a_idx", 64'(src_a_idx), 64'(w[20:16]));
        check("R4", "src_b_idx", 64'(src_b_idx), 64'(w[15:11]));
        m_stalled = m_valid && !rdy;
        if (v && mready)  model_load(w, a, b);
        else if (rdy)     m_valid = 1'b0;
        @(negedge clk);
        check("R7", "out_valid", 64'(out_valid), 64'(m_valid));
        if (m_valid) begin
            check(m_stalled ? "R8" : (m_word ? "R3" : "R1"), "result", out_result, m_res);
            check("R4", "dest", 64'(out_dest), 64'(m_dest));
            check("R5", "illegal", 64'(out_illegal), 64'(m_ill));
            check("R5", "wr_en", 64'(out_wr_en), 64'(m_we));
            check("R6", "cond_we", 64'(out_cond_we), 64'(m_cwe));
            check("R6", "cond", 64'(out_cond), 64'(m_cr));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "out_valid", 64'(out_valid), 64'd0);
        check("R9", "result", out_result, 64'd0);
        check("R9", "cond", 64'(out_cond), 64'd0);
        check("R9", "cond_we", 64'(out_cond_we), 64'd0);
        rst = 1'b0;
        m_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        do_reset();

        // R2: each shift encoding on the same operands
        for (int s = 0; s < 4; s++)
            cyc(1'b1, mk(PO, 5'd3, 5'd1, 5'd2, 2'(s), XF, 1'b0), 64'd100, 64'd3, 1'b1);
        // R3: upper half of B cleared, both variants for contrast
        cyc(1'b1, mk(PO, 5'd7, 5'd4, 5'd5, 2'd0, XW, 1'b0), 64'd10, 64'hFFFF_FFFF_8000_0001, 1'b1);
        cyc(1'b1, mk(PO, 5'd7, 5'd4, 5'd5, 2'd0, XF, 1'b0), 64'd10, 64'hFFFF_FFFF_8000_0001, 1'b1);
        cyc(1'b1, mk(PO, 5'd8, 5'd4, 5'd5, 2'd3, XW, 1'b1), 64'd0, 64'h1234_5678_FFFF_FFFF, 1'b1);
        // R10: carries past bit 63
        cyc(1'b1, mk(PO, 5'd9, 5'd0, 5'd0, 2'd0, XF, 1'b0), 64'd5, 64'h8000_0000_0000_0001, 1'b1);
        cyc(1'b1, mk(PO, 5'd9, 5'd0, 5'd0, 2'd0, XF, 1'b1), 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1);
        // R6: zero, negative, positive with record bit
        cyc(1'b1, mk(PO, 5'd1, 5'd2, 5'd3, 2'd1, XF, 1'b1), 64'hFFFF_FFFF_FFFF_FFF4, 64'd3, 1'b1);
        cyc(1'b1, mk(PO, 5'd1, 5'd2, 5'd3, 2'd0, XF, 1'b1), 64'hF000_0000_0000_0000, 64'd1, 1'b1);
        cyc(1'b1, mk(PO, 5'd1, 5'd2, 5'd3, 2'd0, XW, 1'b1), 64'd1, 64'd1, 1'b1);
        // R5: wrong primary and wrong extended opcode
        cyc(1'b1, mk(6'd23, 5'd6, 5'd2, 5'd3, 2'd0, XF, 1'b1), 64'd1, 64'd1, 1'b1);
        cyc(1'b1, mk(PO, 5'd6, 5'd2, 5'd3, 2'd2, 8'd112, 1'b1), 64'd1, 64'd1, 1'b1);
        // R8 / R7: stall with new words offered, then drain
        cyc(1'b1, mk(PO, 5'd11, 5'd2, 5'd3, 2'd2, XF, 1'b1), 64'd40, 64'd9, 1'b0);
        for (int k = 0; k < 3; k++)
            cyc(1'b1, mk(PO, 5'd12, 5'd2, 5'd3, 2'd1, XW, 1'b0), 64'd1, 64'd2, 1'b0);
        cyc(1'b0, '0, '0, '0, 1'b1);
        cyc(1'b0, '0, '0, '0, 1'b1);

        // mixed random stream
        for (int n = 0; n < 600; n++) begin
            logic [5:0] po;
            logic [7:0] xo;
            int         sel;
            sel = int'($urandom % 6);
            po  = (sel == 4) ? 6'($urandom) : PO;
            xo  = (sel == 5) ? 8'($urandom) : ((sel[0]) ? XW : XF);
            cyc(($urandom % 4) != 0,
                mk(po, 5'($urandom), 5'($urandom), 5'($urandom), 2'($urandom), xo, 1'($urandom)),
                {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 3) != 0);
        end

        // R9: reset while holding a result
        cyc(1'b1, mk(PO, 5'd2, 5'd2, 5'd2, 2'd1, XF, 1'b1), 64'd3, 64'd3, 1'b0);
        do_reset();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule